// File: doc/BRIEF.md
# Gated-Clock Parallel-Load Shift Register

This block is an eight-stage register that sits in a synchronous design. The data that feeds it comes from two slow control lines. A "tick" line and a "hold" line together form an effective clock, which is their logical OR. On each rising edge of that effective clock, the register does one of two things. It either loads all stages at once from a parallel bus, or it shifts one bit in from a serial input. Only the last stage is visible on the serial output. Either control line can act as the clock while the other is held low. Holding either line high freezes the register.

The block never uses the effective clock as a real clock. It passes the OR of the two lines through a two-flop synchronizer on the free-running system clock. It then turns the rising edge into a one-cycle step enable. The mode, serial and parallel inputs are sampled in that enable cycle, so they must be stable around it. An active-low clear resets the stages asynchronously and overrides everything else. A separate system reset only initialises the synchronizer. A debug bus exposes all stages.

Top module: `gated_piso_shreg`

## Requirements
- R1: With `shift_mode_i` low, a step loads every stage from `par_i`. Bit `par_i[0]` goes to the first (serial-side) stage and `par_i[WIDTH-1]` goes to the last (output) stage. `stages_o[i]` shows stage i.
- R2: With `shift_mode_i` high, a step puts `ser_i` into stage 0 and moves each stage i-1 into stage i. That is, `stages_o` becomes `{stages_o[WIDTH-2:0], ser_i}`.
- R3: During a load, `ser_i` has no effect on any stage.
- R4: `ser_o` always equals the last stage, `stages_o[WIDTH-1]`.
- R5: The effective clock is `tick_i | hold_i`. Each low-to-high transition of it causes exactly one step, however long it then stays high. Either input works as the clock while the other is low, and that includes raising `hold_i` while `tick_i` is low.
- R6: While `hold_i` is high, toggling `tick_i` causes no step and the stages keep their value.
- R7: While `clr_ni` is low, all stages and `ser_o` are zero at once, without waiting for a clock. Effective-clock edges that occur during the clear are lost.
- R8: The first system clock edge that samples the effective clock high is edge k. The step enable is then high for the single cycle after edge k+1, and the stages change at edge k+2 and not earlier.
- R9: If the effective clock is already high when `rst_ni` is released, that level causes no step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running system clock |
| rst_ni | input | 1 | Active-low system reset for the edge synchronizer |
| clr_ni | input | 1 | Active-low asynchronous clear of all stages |
| tick_i | input | 1 | Clock-control line, one input of the effective clock |
| hold_i | input | 1 | Clock-control line used as inhibit, the other input of the effective clock |
| shift_mode_i | input | 1 | 1 = shift serially, 0 = parallel load |
| ser_i | input | 1 | Serial data into stage 0 |
| par_i | input | WIDTH | Parallel data, bit i goes to stage i |
| ser_o | output | 1 | Last stage |
| stages_o | output | WIDTH | Debug view of all stages |

## Verification
A change on an effective-clock input becomes visible on the stages three system clock edges after it is driven. It passes the two synchronizer flops, then the update edge. The bench drives every input on a falling system edge. It then waits three falling edges before it compares the stages and the serial output. The latency check looks one edge earlier to confirm that nothing has moved yet. The clear is different: it acts without the clock, so its result is checked one nanosecond after the clear falls, and again after a clock pulse given while the clear is still low.

// File: rtl/gpsr_pkg.sv
package gpsr_pkg;

  typedef enum logic {
    MODE_LOAD  = 1'b0,
    MODE_SHIFT = 1'b1
  } step_mode_e;

  localparam int unsigned DEF_WIDTH      = 8;
  localparam int unsigned DEF_SYNC_DEPTH = 2;

endpackage

// File: rtl/gpsr_edge_sync.sv
module gpsr_edge_sync #(
  parameter int unsigned SYNC_DEPTH = gpsr_pkg::DEF_SYNC_DEPTH
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic rise_o
);

  localparam int unsigned CHAIN = SYNC_DEPTH + 1;

  logic [CHAIN-1:0] chain_q;

  // Reset to all ones: a level already high at reset release is not an edge.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '1;
    end else begin
      chain_q <= {chain_q[CHAIN-2:0], level_i};
    end
  end

  // chain_q[SYNC_DEPTH-1] is the synchronized level, chain_q[SYNC_DEPTH] the previous one.
  assign rise_o = chain_q[SYNC_DEPTH-1] & ~chain_q[SYNC_DEPTH];

endmodule

// File: rtl/gpsr_stage_chain.sv
module gpsr_stage_chain #(
  parameter int unsigned WIDTH = gpsr_pkg::DEF_WIDTH
) (
  input  logic                    clk_i,
  input  logic                    clr_ni,
  input  logic                    step_i,
  input  gpsr_pkg::step_mode_e    mode_i,
  input  logic                    ser_i,
  input  logic [WIDTH-1:0]        par_i,
  output logic [WIDTH-1:0]        stages_o
);

  logic [WIDTH-1:0] feed_w;

  // Source of each stage in shift mode: serial input for stage 0, predecessor otherwise.
  for (genvar g = 0; g < WIDTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      assign feed_w[g] = ser_i;
    end else begin : g_body
      assign feed_w[g] = stages_o[g-1];
    end

    always_ff @(posedge clk_i or negedge clr_ni) begin
      if (!clr_ni) begin
        stages_o[g] <= 1'b0;
      end else if (step_i) begin
        stages_o[g] <= (mode_i == gpsr_pkg::MODE_SHIFT) ? feed_w[g] : par_i[g];
      end
    end
  end

endmodule

// File: rtl/gated_piso_shreg.sv
module gated_piso_shreg #(
  parameter int unsigned WIDTH      = gpsr_pkg::DEF_WIDTH,
  parameter int unsigned SYNC_DEPTH = gpsr_pkg::DEF_SYNC_DEPTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_ni,
  input  logic             tick_i,
  input  logic             hold_i,
  input  logic             shift_mode_i,
  input  logic             ser_i,
  input  logic [WIDTH-1:0] par_i,
  output logic             ser_o,
  output logic [WIDTH-1:0] stages_o
);

  localparam int unsigned LAST = WIDTH - 1;

  logic                 eff_clk_w;
  logic                 step_en;
  gpsr_pkg::step_mode_e mode_w;

  // Either line high blocks the other; their OR is the effective clock.
  assign eff_clk_w = tick_i | hold_i;
  assign mode_w    = gpsr_pkg::step_mode_e'(shift_mode_i);

  gpsr_edge_sync #(
    .SYNC_DEPTH(SYNC_DEPTH)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .level_i(eff_clk_w),
    .rise_o (step_en)
  );

  gpsr_stage_chain #(
    .WIDTH(WIDTH)
  ) u_chain (
    .clk_i   (clk_i),
    .clr_ni  (clr_ni),
    .step_i  (step_en),
    .mode_i  (mode_w),
    .ser_i   (ser_i),
    .par_i   (par_i),
    .stages_o(stages_o)
  );

  assign ser_o = stages_o[LAST];

endmodule

// File: rtl/gated_piso_shreg_chk.sv
module gated_piso_shreg_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_ni,
  input logic             hold_i,
  input logic             shift_mode_i,
  input logic             ser_i,
  input logic [WIDTH-1:0] par_i,
  input logic             ser_o,
  input logic [WIDTH-1:0] stages_o,
  input logic             step_en
);

  p_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni || !clr_ni)
    (step_en && !shift_mode_i) |=> (stages_o == $past(par_i)));

  p_shift_r2: assert property (@(posedge clk_i) disable iff (!rst_ni || !clr_ni)
    (step_en && shift_mode_i) |=> (stages_o == {$past(stages_o[WIDTH-2:0]), $past(ser_i)}));

  p_single_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_en |=> !step_en);

  p_inhibit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(hold_i, 2) && $past(hold_i, 3)) |-> !step_en);

  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |-> (stages_o == '0 && !ser_o));

  p_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni || !clr_ni)
    !step_en |=> $stable(stages_o));

endmodule

bind gated_piso_shreg gated_piso_shreg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .clr_ni      (clr_ni),
  .hold_i      (hold_i),
  .shift_mode_i(shift_mode_i),
  .ser_i       (ser_i),
  .par_i       (par_i),
  .ser_o       (ser_o),
  .stages_o    (stages_o),
  .step_en     (step_en)
);

// File: tb/gated_piso_shreg_test.sv
`timescale 1ns/1ps
module gated_piso_shreg_test;

  localparam int W = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni, clr_ni, tick_i, hold_i, shift_mode_i, ser_i;
  logic [W-1:0] par_i;
  logic         ser_o;
  logic [W-1:0] stages_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  gated_piso_shreg #(.WIDTH(W)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_ni(clr_ni), .tick_i(tick_i),
    .hold_i(hold_i), .shift_mode_i(shift_mode_i), .ser_i(ser_i),
    .par_i(par_i), .ser_o(ser_o), .stages_o(stages_o)
  );

  // {mode, ser, par, expected stages}: mode 1 = shift, 0 = load
  localparam logic [17:0] VEC [0:7] = '{
    {1'b0, 1'b0, 8'hA5, 8'hA5},
    {1'b1, 1'b1, 8'h00, 8'h4B},
    {1'b1, 1'b0, 8'hFF, 8'h96},
    {1'b1, 1'b1, 8'h00, 8'h2D},
    {1'b0, 1'b1, 8'h3C, 8'h3C},
    {1'b1, 1'b0, 8'h00, 8'h78},
    {1'b1, 1'b0, 8'h00, 8'hF0},
    {1'b1, 1'b1, 8'h00, 8'hE1}
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // One rising edge of the effective clock through the chosen line, then back low.
  task automatic pulse(input bit use_hold);
    @(negedge clk_i);
    if (use_hold) hold_i = 1'b1; else tick_i = 1'b1;
    repeat (4) @(negedge clk_i);
    if (use_hold) hold_i = 1'b0; else tick_i = 1'b0;
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; clr_ni = 1'b0; tick_i = 1'b1; hold_i = 1'b0;
    shift_mode_i = 1'b0; ser_i = 1'b0; par_i = 8'hAA;
    repeat (3) @(negedge clk_i);
    check("R7 reset stages", stages_o, '0);
    check("R7 reset ser_o", {7'b0, ser_o}, 8'h00);
    rst_ni = 1'b1; clr_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    check("R9 high level at reset release", stages_o, '0);
    tick_i = 1'b0;
    repeat (3) @(negedge clk_i);

    // Vector table: R1 load, R2 shift, R3 serial ignored on load, R4 output
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      shift_mode_i = VEC[i][17];
      ser_i        = VEC[i][16];
      par_i        = VEC[i][15:8];
      pulse(1'b0);
      check(VEC[i][17] ? "R2 shift" : "R1 R3 load", stages_o, VEC[i][7:0]);
      check("R4 ser_o", {7'b0, ser_o}, {7'b0, VEC[i][7]});
    end

    // R6: tick rise shifts once, then hold raised while tick high freezes it
    @(negedge clk_i);
    shift_mode_i = 1'b1; ser_i = 1'b0;
    tick_i = 1'b1;
    repeat (4) @(negedge clk_i);
    hold_i = 1'b1;
    for (int k = 0; k < 4; k++) begin
      tick_i = 1'b0; repeat (3) @(negedge clk_i);
      tick_i = 1'b1; repeat (3) @(negedge clk_i);
    end
    check("R6 inhibit", stages_o, 8'hC2);
    hold_i = 1'b0; repeat (3) @(negedge clk_i);
    tick_i = 1'b0; repeat (3) @(negedge clk_i);
    check("R6 release with tick high", stages_o, 8'hC2);

    // R5: raising hold while tick is low clocks the register
    ser_i = 1'b1;
    pulse(1'b1);
    check("R5 hold as clock", stages_o, 8'h85);

    // R8 latency, R5 single step on a long high level
    @(negedge clk_i);
    shift_mode_i = 1'b0; par_i = 8'h5A;
    tick_i = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R8 no change after two edges", stages_o, 8'h85);
    @(negedge clk_i);
    check("R8 change on third edge", stages_o, 8'h5A);
    par_i = 8'hFF;
    repeat (6) @(negedge clk_i);
    check("R5 one step per rise", stages_o, 8'h5A);
    tick_i = 1'b0;
    repeat (3) @(negedge clk_i);

    // R7: asynchronous clear, edges lost while clear low
    clr_ni = 1'b0;
    #1;
    check("R7 immediate clear", stages_o, '0);
    check("R7 ser_o cleared", {7'b0, ser_o}, 8'h00);
    par_i = 8'hFF;
    pulse(1'b0);
    check("R7 edge ignored in clear", stages_o, '0);
    clr_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R7 after release", stages_o, '0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule